// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block sits between a PWM generator and the pads. It takes three pairs of PWM signals (channels 0/1, 2/3 and 4/5). For each pair it can hold back the rising edge of both signals by a programmable number of clock cycles. This keeps the high-side and low-side switches of a half bridge from being on at the same moment. Falling edges always pass straight through, so the delay only ever shortens a high pulse. A high pulse that is no longer than the dead time never appears at the output.

Each pair has its own insertion enable bit. The enable takes effect only while the pair's mode input says the pair runs in complementary mode. All three pairs share one 9-bit dead-time count. Its low byte lives in an unprotected count register. Its top bit lives in the enable register next to the pair enables. The enable register is guarded: a write to it is honoured only inside a short window opened by a two-step unlock written to a guard register.

Top module: `dt_insert_top`

## Requirements
- R1: After reset the enable register reads 0x00, the count register reads 0x00, and every output equals its input.
- R2: Register map and read layout:
  - Address 0 is the guard register and always reads 0x00.
  - Address 1 is the enable register. Bits 0, 1 and 2 enable pairs 0/1, 2/3 and 4/5. Bit 4 is bit 8 of the dead-time count. Bits 7:5 and bit 3 always read 0.
  - Address 2 holds bits 7:0 of the count.
  - Address 3 reads 0x00.
- R3: A write to address 1 changes the enable register only when it follows an unlock. An unlock is a write of 0xAA to address 0, with the very next write being 0x55 to address 0. Without an unlock the write is ignored.
- R4: The unlock opens a window of 4 clock cycles after the 0x55 write.
  - A write to address 1 sampled 4 cycles after the 0x55 write is accepted.
  - A write sampled 5 cycles after it is ignored.
  - Only one protected write is accepted per unlock.
- R5: Any other write between 0xAA and 0x55 breaks the unlock. This includes a write to the count register or a different value to address 0.
- R6: Consider a pair that is enabled and in complementary mode, with count N > 0. A rising edge on either of its inputs appears at the matching output N cycles later, provided the input is still high.
- R7: A count of 0 gives no delay, even with insertion active.
- R8: A falling input edge drives the output low in the same cycle, and an output is never high while its input is low. An input pulse of W cycles with W <= N gives no output pulse. With W > N it gives an output pulse of W - N cycles.
- R9: A pair whose enable bit is 0, or whose mode input is 0, passes its inputs to its outputs unchanged.
- R10: Both outputs of a pair use the shared count. Each pair acts on its own enable and mode regardless of the other pairs' settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| comp_mode | input | 3 | Per-pair complementary-mode flag, bit p for pair p |
| pwm_in | input | 6 | PWM inputs, channel c in bit c; pair p uses bits 2p and 2p+1 |
| pwm_out | output | 6 | PWM outputs after dead-time insertion |

## Verification
The assertions assume the following about the inputs:
- `wr_en`, `addr`, `wdata`, `pwm_in` and `comp_mode` are synchronous to `clk` and settle well before each rising edge.
- A rise on a PWM input is seen first at the edge where it is sampled.

The bench keeps within this by changing every input only on the falling clock edge. Reset is held high from time zero through the first edges. Register writes are issued back to back only where an unlock sequence calls for it, so the window and sequence rules are exercised only by intent.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int NUM_PAIRS = 3;
    localparam int NUM_CH    = 2 * NUM_PAIRS;
    localparam int CNT_W     = 9;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_GUARD = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENBL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

    localparam int HI_BIT_POS = 4;

    typedef enum logic [1:0] {
        GUARD_IDLE,
        GUARD_ARMED,
        GUARD_OPEN
    } guard_state_t;

    typedef struct packed {
        logic [NUM_PAIRS-1:0] pair_en;
        logic [CNT_W-1:0]     dead_cnt;
    } dt_cfg_t;

    function automatic logic [DATA_W-1:0] pack_enable(input dt_cfg_t cfg);
        logic [DATA_W-1:0] v;
        v = '0;
        v[NUM_PAIRS-1:0] = cfg.pair_en;
        v[HI_BIT_POS]    = cfg.dead_cnt[CNT_W-1];
        return v;
    endfunction

endpackage

// File: rtl/dt_regfile.sv
module dt_regfile
    import dt_pkg::*;
#(
    parameter int WIN_CYC = 4,
    localparam int TMR_W = $clog2(WIN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output dt_cfg_t           cfg
);

    guard_state_t     gstate;
    logic [TMR_W-1:0] win_tmr;
    dt_cfg_t          cfg_q;
    logic             window_open;

    assign window_open = (gstate == GUARD_OPEN) && (win_tmr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gstate  <= GUARD_IDLE;
            win_tmr <= '0;
            cfg_q   <= '0;
        end else if (wr_en) begin
            if (addr == A_ENBL && window_open) begin
                cfg_q.pair_en            <= wdata[NUM_PAIRS-1:0];
                cfg_q.dead_cnt[CNT_W-1]  <= wdata[HI_BIT_POS];
            end
            if (addr == A_COUNT) begin
                cfg_q.dead_cnt[CNT_W-2:0] <= wdata;
            end
            if (addr == A_GUARD && wdata == KEY_FIRST) begin
                gstate  <= GUARD_ARMED;
                win_tmr <= '0;
            end else if (addr == A_GUARD && wdata == KEY_SECOND
                         && gstate == GUARD_ARMED) begin
                gstate  <= GUARD_OPEN;
                win_tmr <= TMR_W'(WIN_CYC);
            end else begin
                gstate  <= GUARD_IDLE;
                win_tmr <= '0;
            end
        end else if (gstate == GUARD_OPEN) begin
            if (win_tmr <= TMR_W'(1)) begin
                gstate  <= GUARD_IDLE;
                win_tmr <= '0;
            end else begin
                win_tmr <= win_tmr - 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_ENBL:  rdata = pack_enable(cfg_q);
            A_COUNT: rdata = cfg_q.dead_cnt[CNT_W-2:0];
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/dt_edge_delay.sv
module dt_edge_delay
    import dt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] load_val,
    input  logic          din,
    output logic          dout
);

    logic          din_q;
    logic [CW-1:0] remain;
    logic          rise;
    logic          hold_low;

    assign rise     = din && !din_q;
    assign hold_low = active && (rise ? (load_val != '0) : (remain != '0));
    assign dout     = din && !hold_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= 1'b0;
            remain <= '0;
        end else begin
            din_q <= din;
            if (!active || !din) begin
                remain <= '0;
            end else if (rise) begin
                remain <= (load_val == '0) ? '0 : load_val - 1'b1;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dt_pair.sv
module dt_pair
    import dt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             comp,
    input  logic [CNT_W-1:0] dead_cnt,
    input  logic [1:0]       pin,
    output logic [1:0]       pout
);

    logic active;
    assign active = enable && comp;

    for (genvar s = 0; s < 2; s++) begin : g_side
        dt_edge_delay #(.CW(CNT_W)) u_side (
            .clk      (clk),
            .rst      (rst),
            .active   (active),
            .load_val (dead_cnt),
            .din      (pin[s]),
            .dout     (pout[s])
        );
    end

endmodule

// File: rtl/dt_insert_top.sv
module dt_insert_top
    import dt_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_PAIRS-1:0] comp_mode,
    input  logic [NUM_CH-1:0]    pwm_in,
    output logic [NUM_CH-1:0]    pwm_out
);

    dt_cfg_t              cfg;
    logic [NUM_PAIRS-1:0] pair_en;
    logic [CNT_W-1:0]     dead_cnt;

    dt_regfile #(.WIN_CYC(WIN_CYC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .cfg   (cfg)
    );

    assign pair_en  = cfg.pair_en;
    assign dead_cnt = cfg.dead_cnt;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dt_pair u_pair (
            .clk      (clk),
            .rst      (rst),
            .enable   (pair_en[p]),
            .comp     (comp_mode[p]),
            .dead_cnt (dead_cnt),
            .pin      (pwm_in[2*p+1:2*p]),
            .pout     (pwm_out[2*p+1:2*p])
        );
    end

endmodule

// File: rtl/dt_insert_checker.sv
module dt_insert_checker
    import dt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_PAIRS-1:0] comp_mode,
    input logic [NUM_CH-1:0]    pwm_in,
    input logic [NUM_CH-1:0]    pwm_out,
    input logic [NUM_PAIRS-1:0] pair_en,
    input logic [CNT_W-1:0]     dead_cnt
);

    logic [NUM_PAIRS-1:0] act;
    assign act = pair_en & comp_mode;

    // R2: reserved enable-register bits read as zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (addr == A_ENBL) |-> (rdata[7:5] == 3'b000 && rdata[3] == 1'b0));

    // R3: the protected register moves only after a write to its address
    p_guarded_write_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && addr == A_ENBL) |-> $stable({pair_en, dead_cnt[CNT_W-1]}));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R8: an output is never high while its input is low
        p_never_above_in_r8: assert property (@(posedge clk) disable iff (rst)
            !pwm_in[i] |-> !pwm_out[i]);

        // R6: a fresh rising edge is held back when insertion is active
        p_rise_held_r6: assert property (@(posedge clk) disable iff (rst)
            ($rose(pwm_in[i]) && act[i/2] && dead_cnt != '0) |-> !pwm_out[i]);

        // R9: inactive pairs pass straight through
        p_off_pass_r9: assert property (@(posedge clk) disable iff (rst)
            !act[i/2] |-> (pwm_out[i] == pwm_in[i]));
    end

endmodule

bind dt_insert_top dt_insert_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .comp_mode (comp_mode),
    .pwm_in    (pwm_in),
    .pwm_out   (pwm_out),
    .pair_en   (pair_en),
    .dead_cnt  (dead_cnt)
);

// File: tb/tb_dt_insert_top.sv
module tb_dt_insert_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] comp_mode = 3'b000;
    logic [5:0] pwm_in = 6'd0;
    logic [5:0] pwm_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dt_insert_top dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .comp_mode (comp_mode),
        .pwm_in    (pwm_in),
        .pwm_out   (pwm_out)
    );

    // {count, pulse width, first high cycle, high length}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{3, 8, 3, 5},
        '{0, 5, 0, 5},
        '{1, 2, 1, 1},
        '{4, 4, 0, 0},
        '{4, 3, 0, 0},
        '{7, 20, 7, 13},
        '{2, 3, 2, 1},
        '{5, 6, 5, 1}
    };

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        check(int'(rdata), int'(exp), tag);
    endtask

    task automatic unlock();
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
    endtask

    task automatic pulse(input int ch, input int w, input int first_exp,
                         input int len_exp, input string tag);
        int first = -1;
        int len = 0;
        pwm_in[ch] = 1'b1;
        for (int k = 0; k < w; k++) begin
            #9;
            if (pwm_out[ch] && first < 0) first = k;
            if (pwm_out[ch]) len++;
            @(negedge clk);
            if (k == w - 1) pwm_in[ch] = 1'b0;
        end
        #1;
        check(int'(pwm_out[ch]), 0, {tag, " falling edge"});
        check(len, len_exp, {tag, " high length"});
        if (len_exp > 0) check(first, first_exp, {tag, " delay"});
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_check(2'd1, 8'h00, "R1 enable after reset");
        rd_check(2'd2, 8'h00, "R1 count after reset");
        pwm_in = 6'b101010;
        comp_mode = 3'b111;
        #1;
        check(int'(pwm_out), int'(6'b101010), "R1 passthrough after reset");
        @(negedge clk);
        pwm_in = 6'd0;
        @(negedge clk);

        // R3 locked write ignored
        wr(2'd1, 8'h17);
        rd_check(2'd1, 8'h00, "R3 write without unlock");

        // R2/R3 layout after unlocked write
        unlock();
        wr(2'd1, 8'hFF);
        rd_check(2'd1, 8'h17, "R2 R3 enable layout");
        rd_check(2'd0, 8'h00, "R2 guard reads zero");
        rd_check(2'd3, 8'h00, "R2 unused address");
        wr(2'd2, 8'h5A);
        rd_check(2'd2, 8'h5A, "R2 count low byte");

        // R4 window edges and single write
        unlock();
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h07);
        rd_check(2'd1, 8'h07, "R4 write in last window cycle");
        wr(2'd1, 8'h01);
        rd_check(2'd1, 8'h07, "R4 second write after unlock");
        unlock();
        repeat (4) @(negedge clk);
        wr(2'd1, 8'h00);
        rd_check(2'd1, 8'h07, "R4 write after window closed");

        // R5 broken sequences
        wr(2'd0, 8'hAA);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h55);
        wr(2'd1, 8'h00);
        rd_check(2'd1, 8'h07, "R5 count write breaks unlock");
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h12);
        wr(2'd0, 8'h55);
        wr(2'd1, 8'h00);
        rd_check(2'd1, 8'h07, "R5 wrong key breaks unlock");

        // R6 R7 R8 R10 vector table over all channels
        comp_mode = 3'b111;
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd2, 8'(VEC[i][0]));
            @(negedge clk);
            pulse(i % 6, VEC[i][1], VEC[i][2], VEC[i][3],
                  $sformatf("R6 R7 R8 R10 vec%0d", i));
        end

        // R6 nine-bit count via bit 4 of the enable register
        unlock();
        wr(2'd1, 8'h17);
        wr(2'd2, 8'h04);
        pulse(4, 265, 260, 5, "R6 nine-bit count");

        // R9 pair 2/3 disabled, R10 other pairs keep their own setting
        unlock();
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h05);
        pulse(2, 3, 0, 3, "R9 enable off passes");
        comp_mode = 3'b110;
        @(negedge clk);
        pulse(1, 3, 0, 3, "R9 mode off passes");
        pulse(5, 8, 5, 3, "R10 pair 4/5 unaffected");

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check(2'd1, 8'h00, "R1 enable after second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule